// File: doc/BRIEF.md
# Dual-Pipe Multithreaded SIMD Issue Sequencer

This block is the issue stage of one GPU execution unit. It holds seven hardware thread slots. Each slot carries a logical SIMD width of 8, 16 or 32 work items and an operand-size flag. Each cycle it feeds two narrow SIMD pipelines. A wide instruction is cut into successive passes, and each pass covers one lane group: four lanes for 32-bit work, eight lanes for 16-bit work. The pipe therefore stays busy for a number of consecutive cycles that depends on the instruction width. Total throughput is the same whatever logical width the threads use.

The block has one picker and two pipe sequencers. The picker grants ready threads in rotating-priority order. Each pipe sequencer is a two-state machine with states `PS_IDLE` and `PS_RUN`. It has four named transitions:

- **start**: `PS_IDLE` to `PS_RUN` on a grant.
- **step**: `PS_RUN` to `PS_RUN`. The group index advances.
- **chain**: `PS_RUN` to `PS_RUN`. On the final pass a new grant loads another thread.
- **drain**: `PS_RUN` to `PS_IDLE`. On the final pass there is no grant.

A grant made in cycle t produces the first pass in cycle t+1. Each pass carries the slice of the thread's execution mask for that lane group, and the block does not change it. No arithmetic is performed. The pass outputs are tokens that downstream lanes would consume.

Top module: `eu_issue_seq`

## Requirements
- R1: Only slots 0 to 6 are ever issued, and a slot is granted only in a cycle where its ready bit is high.
- R2: Each of the two pipes issues at most one pass per cycle, and the two pipes never carry the same slot in the same cycle.
- R3: For 32-bit work (half flag 0), the width code selects the number of passes:
  - code 2'b00 (8 items) gives 2 passes;
  - code 2'b01 (16 items) gives 4 passes;
  - codes 2'b10 and 2'b11 (32 items) give 8 passes.
  The passes run on consecutive cycles of one pipe, with group index 0, 1, 2 and so on.
- R4: With the half flag set (16-bit work), each pass covers 8 lanes. The pass counts become 1, 2 and 4 for the three widths.
- R5: `iss_done` for a pipe is high exactly in the cycle of an instruction's final pass, and in no other cycle.
- R6: A slot is not eligible for a grant in any cycle in which it occupies a pipe, including its final-pass cycle. A slot's next pass therefore comes at least two cycles after its final pass.
- R7: Free pipes take eligible slots in cyclic order, starting at a priority pointer.
  - Pipe 0 takes first; if pipe 0 is busy, pipe 1 takes the first eligible slot.
  - After any grant, the pointer moves to the slot just after the last slot granted.
  - A pipe is free when it is idle or on its final pass.
- R8: `iss_mask` for a pipe carries lanes g*L to g*L+L-1 of the issued slot's current mask input, with lane g*L+k on bit k.
  - g is the group index, and L is 4, or 8 with the half flag set.
  - The bits at and above L are zero.
  - Groups whose mask slice is all zero are still issued on their cycle.
- R9: While reset is held, no pass is issued.
  - After release, the priority pointer starts at slot 0.
- R10: A slot's width and half flag are sampled when it is granted. Changing them while the instruction runs does not change its pass count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_ready | input | NUM_THR | Per-slot ready bits |
| thr_width | input | 2*NUM_THR | Per-slot width code, 2 bits per slot |
| thr_half | input | NUM_THR | Per-slot 16-bit operation flag |
| thr_mask | input | 32*NUM_THR | Per-slot 32-lane execution mask |
| iss_vld | output | 2 | Pass valid, one bit per pipe |
| iss_tid | output | 2*TID_W | Slot of each pipe's pass |
| iss_grp | output | 6 | Lane-group index of each pipe's pass, 3 bits per pipe |
| iss_mask | output | 16 | Mask slice of each pipe's pass, 8 bits per pipe |
| iss_done | output | 2 | Final-pass pulse, one bit per pipe |

## Verification
The bench targets the following corner cases.

- **Lone slot.** A single ready slot tests the re-grant gap. A design that let a slot re-arbitrate during its own final pass would show a pass in the very next cycle.
- **All slots ready.** Keeping every slot ready tests the rotating pointer and the exclusion between pipes. A fixed-priority picker would starve the high slots, and a missing exclusion would place one slot on both pipes.
- **16-bit work and attribute changes.** The bench mixes 16-bit and 32-bit work with random width codes, including code 2'b11. It also changes the attributes during a run. An attribute read live instead of latched at grant would cut instructions short or stretch them.
- **Masks.** Random and all-zero masks test the slicing. A wrong lane offset would show as a mismatched slice, and skipping empty groups would break the pass sequence.

// File: rtl/eu_pkg.sv
package eu_pkg;
    localparam int NUM_PIPE = 2;
    localparam int MAXW     = 32;
    localparam int GRP_W    = 3;
    localparam int SLICE_W  = 8;

    typedef enum logic {PS_IDLE, PS_RUN} pipe_st_e;

    // index of the final pass for a width code and operand size
    function automatic logic [GRP_W-1:0] final_pass(input logic [1:0] wcode, input logic half);
        logic [GRP_W-1:0] r;
        unique case (wcode)
            2'b00:   r = half ? 3'd0 : 3'd1;
            2'b01:   r = half ? 3'd1 : 3'd3;
            default: r = half ? 3'd3 : 3'd7;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/eu_pick.sv
module eu_pick import eu_pkg::*; #(
    parameter int NUM_THR = 7,
    localparam int TID_W  = $clog2(NUM_THR)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_THR-1:0]          elig,
    input  logic [NUM_PIPE-1:0]         free,
    output logic [NUM_PIPE-1:0]         gnt,
    output logic [NUM_PIPE*TID_W-1:0]   gtid
);
    logic [TID_W-1:0] ptr_q, ptr_d;
    logic [TID_W-1:0] first_s, second_s;
    logic             has_first, has_second;

    // scan slots cyclically from the pointer, keep the first two eligible
    always_comb begin
        int idx;
        first_s    = '0;
        second_s   = '0;
        has_first  = 1'b0;
        has_second = 1'b0;
        for (int i = 0; i < NUM_THR; i++) begin
            idx = int'(ptr_q) + i;
            if (idx >= NUM_THR) idx = idx - NUM_THR;
            if (elig[idx]) begin
                if (!has_first) begin
                    first_s   = TID_W'(idx);
                    has_first = 1'b1;
                end else if (!has_second) begin
                    second_s   = TID_W'(idx);
                    has_second = 1'b1;
                end
            end
        end
    end

    always_comb begin
        logic [TID_W-1:0] lastg;
        gnt   = '0;
        gtid  = '0;
        lastg = '0;
        if (free[0]) begin
            gnt[0]         = has_first;
            gtid[0+:TID_W] = first_s;
            gnt[1]         = free[1] && has_second;
            gtid[TID_W+:TID_W] = second_s;
            lastg          = gnt[1] ? second_s : first_s;
        end else begin
            gnt[1]             = free[1] && has_first;
            gtid[TID_W+:TID_W] = first_s;
            lastg              = first_s;
        end
        ptr_d = ptr_q;
        if (|gnt) ptr_d = (int'(lastg) == NUM_THR-1) ? '0 : lastg + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end
endmodule

// File: rtl/eu_pipe.sv
module eu_pipe import eu_pkg::*; #(
    parameter int NUM_THR = 7,
    localparam int TID_W  = $clog2(NUM_THR)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     gnt_i,
    input  logic [TID_W-1:0]         gtid_i,
    input  logic [1:0]               gwidth_i,
    input  logic                     ghalf_i,
    input  logic [MAXW*NUM_THR-1:0]  thr_mask_i,
    output logic                     vld_o,
    output logic [TID_W-1:0]         tid_o,
    output logic [GRP_W-1:0]         grp_o,
    output logic [SLICE_W-1:0]       mask_o,
    output logic                     done_o,
    output logic                     free_o
);
    pipe_st_e         st_q;
    logic [TID_W-1:0] tid_q;
    logic [GRP_W-1:0] grp_q, last_q;
    logic             half_q;

    // state register: start / step / chain / drain
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= PS_IDLE;
            tid_q  <= '0;
            grp_q  <= '0;
            last_q <= '0;
            half_q <= 1'b0;
        end else begin
            unique case (st_q)
                PS_IDLE: if (gnt_i) begin
                    st_q   <= PS_RUN;
                    tid_q  <= gtid_i;
                    grp_q  <= '0;
                    last_q <= final_pass(gwidth_i, ghalf_i);
                    half_q <= ghalf_i;
                end
                PS_RUN: begin
                    if (grp_q != last_q) begin
                        grp_q <= grp_q + 1'b1;
                    end else if (gnt_i) begin
                        tid_q  <= gtid_i;
                        grp_q  <= '0;
                        last_q <= final_pass(gwidth_i, ghalf_i);
                        half_q <= ghalf_i;
                    end else begin
                        st_q <= PS_IDLE;
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        logic [MAXW-1:0] lanes;
        logic [MAXW-1:0] shifted;
        lanes   = thr_mask_i[int'(tid_q)*MAXW +: MAXW];
        shifted = half_q ? (lanes >> {grp_q, 3'b000}) : (lanes >> {grp_q, 2'b00});
        vld_o   = 1'b0;
        tid_o   = '0;
        grp_o   = '0;
        mask_o  = '0;
        done_o  = 1'b0;
        free_o  = 1'b1;
        unique case (st_q)
            PS_IDLE: free_o = 1'b1;
            PS_RUN: begin
                vld_o  = 1'b1;
                tid_o  = tid_q;
                grp_o  = grp_q;
                mask_o = half_q ? shifted[7:0] : {4'b0000, shifted[3:0]};
                done_o = (grp_q == last_q);
                free_o = (grp_q == last_q);
            end
        endcase
    end
endmodule

// File: rtl/eu_issue_seq.sv
module eu_issue_seq import eu_pkg::*; #(
    parameter int NUM_THR = 7,
    localparam int TID_W  = $clog2(NUM_THR)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_THR-1:0]          thr_ready,
    input  logic [2*NUM_THR-1:0]        thr_width,
    input  logic [NUM_THR-1:0]          thr_half,
    input  logic [MAXW*NUM_THR-1:0]     thr_mask,
    output logic [NUM_PIPE-1:0]         iss_vld,
    output logic [NUM_PIPE*TID_W-1:0]   iss_tid,
    output logic [NUM_PIPE*GRP_W-1:0]   iss_grp,
    output logic [NUM_PIPE*SLICE_W-1:0] iss_mask,
    output logic [NUM_PIPE-1:0]         iss_done
);
    logic [NUM_PIPE-1:0]       free;
    logic [NUM_PIPE-1:0]       gnt;
    logic [NUM_PIPE*TID_W-1:0] gtid;
    logic [NUM_THR-1:0]        busy, elig;

    always_comb begin
        busy = '0;
        for (int p = 0; p < NUM_PIPE; p++)
            if (iss_vld[p]) busy[iss_tid[p*TID_W +: TID_W]] = 1'b1;
        elig = thr_ready & ~busy;
    end

    eu_pick #(.NUM_THR(NUM_THR)) u_pick (
        .clk  (clk),
        .rst_n(rst_n),
        .elig (elig),
        .free (free),
        .gnt  (gnt),
        .gtid (gtid)
    );

    for (genvar p = 0; p < NUM_PIPE; p++) begin : g_pipe
        logic [TID_W-1:0] sel;
        assign sel = gtid[p*TID_W +: TID_W];
        eu_pipe #(.NUM_THR(NUM_THR)) u_pipe (
            .clk       (clk),
            .rst_n     (rst_n),
            .gnt_i     (gnt[p]),
            .gtid_i    (sel),
            .gwidth_i  (thr_width[int'(sel)*2 +: 2]),
            .ghalf_i   (thr_half[sel]),
            .thr_mask_i(thr_mask),
            .vld_o     (iss_vld[p]),
            .tid_o     (iss_tid[p*TID_W +: TID_W]),
            .grp_o     (iss_grp[p*GRP_W +: GRP_W]),
            .mask_o    (iss_mask[p*SLICE_W +: SLICE_W]),
            .done_o    (iss_done[p]),
            .free_o    (free[p])
        );
    end
endmodule

// File: rtl/eu_issue_chk.sv
module eu_issue_chk #(
    parameter int NUM_THR = 7,
    localparam int TID_W  = $clog2(NUM_THR)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         iss_vld,
    input logic [2*TID_W-1:0] iss_tid,
    input logic [5:0]         iss_grp,
    input logic [15:0]        iss_mask,
    input logic [1:0]         iss_done
);
    assert_distinct_threads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_vld[0] && iss_vld[1]) |-> (iss_tid[0+:TID_W] != iss_tid[TID_W+:TID_W]));

    for (genvar p = 0; p < 2; p++) begin : g_chk
        assert_slot_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
            iss_vld[p] |-> (int'(iss_tid[p*TID_W+:TID_W]) < NUM_THR));

        assert_done_on_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
            iss_done[p] |-> iss_vld[p]);

        assert_pass_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (iss_vld[p] && !iss_done[p]) |=> (iss_vld[p]
                && iss_tid[p*TID_W+:TID_W] == $past(iss_tid[p*TID_W+:TID_W])
                && iss_grp[p*3+:3] == $past(iss_grp[p*3+:3]) + 3'd1));

        assert_first_group_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(iss_vld[p]) |-> (iss_grp[p*3+:3] == 3'd0));

        assert_no_regrant_R6: assert property (@(posedge clk) disable iff (!rst_n)
            iss_done[p] |=> !((iss_vld[0] && iss_tid[0+:TID_W] == $past(iss_tid[p*TID_W+:TID_W]))
                           || (iss_vld[1] && iss_tid[TID_W+:TID_W] == $past(iss_tid[p*TID_W+:TID_W]))));

        assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !iss_vld[p] |-> (iss_mask[p*8+:8] == 8'h00 && !iss_done[p]));
    end
endmodule

bind eu_issue_seq eu_issue_chk #(.NUM_THR(NUM_THR)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .iss_vld (iss_vld),
    .iss_tid (iss_tid),
    .iss_grp (iss_grp),
    .iss_mask(iss_mask),
    .iss_done(iss_done)
);

// File: tb/sim_eu_issue_seq.sv
module sim_eu_issue_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 7;
    localparam int TW = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NT-1:0]  thr_ready = '0;
    logic [2*NT-1:0] thr_width = '0;
    logic [NT-1:0]  thr_half = '0;
    logic [32*NT-1:0] thr_mask = '0;
    logic [1:0]     iss_vld;
    logic [2*TW-1:0] iss_tid;
    logic [5:0]     iss_grp;
    logic [15:0]    iss_mask;
    logic [1:0]     iss_done;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    // behavioural reference state
    int m_act[2], m_tid[2], m_grp[2], m_last[2], m_half[2];
    int m_ptr;

    always #(CLK_PERIOD/2) clk = ~clk;

    eu_issue_seq u0 (
        .clk(clk), .rst_n(rst_n), .thr_ready(thr_ready), .thr_width(thr_width),
        .thr_half(thr_half), .thr_mask(thr_mask), .iss_vld(iss_vld), .iss_tid(iss_tid),
        .iss_grp(iss_grp), .iss_mask(iss_mask), .iss_done(iss_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int pass_count(input int w, input int h);
        int n;
        n = (w == 0) ? 2 : (w == 1) ? 4 : 8;
        return h ? n / 2 : n;
    endfunction

    task automatic compare();
        for (int p = 0; p < 2; p++) begin
            int lanes, expm, actm;
            check(iss_vld[p] == m_act[p][0], "R2 pass valid", iss_vld[p], m_act[p]);
            if (m_act[p] != 0) begin
                lanes = m_half[p] ? 8 : 4;
                expm = 0;
                for (int k = 0; k < lanes; k++)
                    if (thr_mask[m_tid[p]*32 + m_grp[p]*lanes + k]) expm |= (1 << k);
                actm = int'(iss_mask[p*8 +: 8]);
                check(int'(iss_tid[p*TW +: TW]) == m_tid[p], "R7 slot order", int'(iss_tid[p*TW +: TW]), m_tid[p]);
                check(int'(iss_grp[p*3 +: 3]) == m_grp[p], "R3 group index", int'(iss_grp[p*3 +: 3]), m_grp[p]);
                check(actm == expm, "R8 mask slice", actm, expm);
                check(iss_done[p] == (m_grp[p] == m_last[p]), "R5 final pulse", iss_done[p], int'(m_grp[p] == m_last[p]));
            end
        end
    endtask

    // advance the reference model by one clock using current inputs
    task automatic step();
        bit busy[NT];
        bit fr[2];
        int picks[$];
        int gnt[2], gt[2];
        for (int t = 0; t < NT; t++) busy[t] = 0;
        for (int p = 0; p < 2; p++) begin
            if (m_act[p] != 0) busy[m_tid[p]] = 1;
            fr[p] = (m_act[p] == 0) || (m_grp[p] == m_last[p]);
            gnt[p] = 0; gt[p] = 0;
        end
        for (int i = 0; i < NT; i++) begin
            int s = (m_ptr + i) % NT;
            if (thr_ready[s] && !busy[s]) picks.push_back(s);
        end
        for (int p = 0; p < 2; p++)
            if (fr[p] && picks.size() > 0) begin
                gnt[p] = 1; gt[p] = picks.pop_front(); m_ptr = (gt[p] + 1) % NT;
            end
        for (int p = 0; p < 2; p++) begin
            if (gnt[p] != 0) begin
                m_act[p] = 1; m_tid[p] = gt[p]; m_grp[p] = 0;
                m_half[p] = int'(thr_half[gt[p]]);
                m_last[p] = pass_count(int'(thr_width[gt[p]*2 +: 2]), m_half[p]) - 1;
            end else if (m_act[p] != 0 && m_grp[p] != m_last[p]) m_grp[p]++;
            else m_act[p] = 0;
        end
    endtask

    task automatic run(input int cycles, input bit rand_mode);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            if (rand_mode) begin
                thr_ready = NT'($urandom);
                if ($urandom % 4 == 0) thr_width = (2*NT)'($urandom);
                if ($urandom % 4 == 0) thr_half  = NT'($urandom);
                for (int t = 0; t < NT; t++)
                    thr_mask[t*32 +: 32] = ($urandom % 5 == 0) ? 32'h0 : $urandom;
            end
            #1;
            compare();
            step();
        end
    endtask

    initial begin
        for (int p = 0; p < 2; p++) begin
            m_act[p] = 0; m_tid[p] = 0; m_grp[p] = 0; m_last[p] = 0; m_half[p] = 0;
        end
        m_ptr = 0;
        thr_ready = '1;
        thr_mask = {NT{32'hA5C3_0F96}};
        // R9: nothing issues while reset is held
        repeat (3) begin
            @(negedge clk); #1;
            check(iss_vld == 2'b00, "R9 reset quiet", iss_vld, 0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        // R9, R7: all slots ready from release; pointer starts at slot 0
        #1; compare(); step();
        run(30, 0);
        // R3, R6: a lone slot of each width, 32-bit work
        for (int w = 0; w < 4; w++) begin
            @(negedge clk);
            thr_ready = 7'b000_0001; thr_width = (2*NT)'(w); thr_half = '0;
            #1; compare(); step();
            run(25, 0);
        end
        // R4: 16-bit work, lone slot and then two slots
        for (int w = 0; w < 3; w++) begin
            @(negedge clk);
            thr_ready = 7'b000_0100; thr_width = (2*NT)'(w << 4); thr_half = 7'b000_0100;
            #1; compare(); step();
            run(15, 0);
        end
        @(negedge clk);
        thr_ready = 7'b010_0100; thr_half = 7'b000_0100; thr_width = {2'b00, 2'b10, 2'b00, 2'b00, 2'b10, 2'b00, 2'b00};
        #1; compare(); step();
        run(30, 0);
        // R8: all-zero masks on a running slot are still sequenced
        @(negedge clk);
        thr_ready = 7'b000_1000; thr_width = '1; thr_half = '0; thr_mask = '0;
        #1; compare(); step();
        run(20, 0);
        // R1, R10: random ready, attribute changes mid-instruction, random masks
        run(3000, 1);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule